// File: doc/BRIEF.md
# SPI Register Target with Frame-Phase Output

This block is a serial-peripheral target that exposes a small bank of 8-bit registers. Each transaction is a fixed frame of sixteen SCLK cycles. The first byte is a command: its top bit picks the direction and its low seven bits pick the register. The second byte carries the data. On a write, the target captures the data byte. On a read, the target shifts the register's contents out.

The target drives a dedicated phase output, `addr_phase_o`. This output is high while the target expects command bits and low while it moves data bits. A controller that has slipped by a few bits can see the mismatch on this pin. It then brings the target back into step by pulsing the active-low resync input. That input also clears the register contents.

The serial pins are oversampled by the system clock through a synchronizer chain. SCLK edges are detected from the sampled waveform. SPI mode 0 is used: input bits are taken on SCLK rising edges, output bits change on falling edges, and bits are sent MSB first.

Top module: `spi_phase_target`

## Requirements
- R1: After `resync_n_i` has been low for a clock edge, `addr_phase_o` reads 1, `sdo_o` reads 0, and every register reads 0x00.
- R2: From the start of a frame, `addr_phase_o` stays 1 through the first seven SCLK rising edges and drops to 0 once the eighth has been taken.
- R3: `addr_phase_o` stays 0 through the data byte and returns to 1 once the sixteenth rising edge of the frame has been taken.
- R4: A command byte with bit 7 = 0 is a write. Bits 6:0 address the register, and the data byte, received MSB first, is stored there at the end of the frame.
- R5: A command byte with bit 7 = 1 is a read. During the data byte, `sdo_o` presents the addressed register MSB first. Each bit is updated after a SCLK falling edge and is valid at the following rising edge.
- R6: While `cs_n_i` is high, SCLK edges are ignored. The bit position and phase are kept, so a frame can be paused and resumed. Raising chip select never restarts a frame.
- R7: Pulling `resync_n_i` low in the middle of a frame discards the partial frame. The next SCLK rising edge is bit 7 of a new command byte.
- R8: The bank holds NUM_REGS registers (default 16). A write to an address at or above NUM_REGS is dropped, and a read of such an address returns 0x00.
- R9: While `burst_en_i` is 1, SCLK edges are ignored and the phase and bit position do not move. Only the normal one-command, one-data framing is carried out.
- R10: `sdo_o` is 0 whenever `addr_phase_o` is 1, and stays 0 through the data byte of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| resync_n_i | input | 1 | Synchronous active-low reset and resync: clears phase, bit count and registers |
| burst_en_i | input | 1 | Framing select: 0 gives normal framing, 1 holds the target idle |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial data to the controller |
| addr_phase_o | output | 1 | Phase indicator: 1 in the command byte, 0 in the data byte |

## Verification
The assertions rely on three conditions on the inputs. `resync_n_i` is held low for several clocks at start-up. SCLK is low while reset is active. Each SCLK level lasts longer than the synchronizer depth plus one clock, so every edge is seen exactly once, and the read data is ready before the first falling edge of the data byte. The stimulus keeps each SCLK half period at six system clocks and changes SDI only while SCLK is low. It also holds SCLK low around every resync pulse, chip-select pause and change of `burst_en_i`. Under these conditions, the phase output may change only on a counted rising edge, a write never reaches the bank with an out-of-range address, and the output pin is silent in the command byte.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
  typedef enum logic {
    PH_DATA = 1'b0,
    PH_ADDR = 1'b1
  } phase_e;

  localparam int CMD_W = 8;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic resync_n_i,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sel_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sclk_q, csn_q, sdi_q;
  logic              sclk_last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (!resync_n_i) begin
          sclk_q <= '0;
          csn_q  <= '1;
          sdi_q  <= '0;
        end else begin
          sclk_q <= sclk_i;
          csn_q  <= cs_n_i;
          sdi_q  <= sdi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (!resync_n_i) begin
          sclk_q <= '0;
          csn_q  <= '1;
          sdi_q  <= '0;
        end else begin
          sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
          csn_q  <= {csn_q[STAGES-2:0], cs_n_i};
          sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!resync_n_i) sclk_last_q <= 1'b0;
    else             sclk_last_q <= sclk_q[STAGES-1];
  end

  assign rise_o = sclk_q[STAGES-1] & ~sclk_last_q;
  assign fall_o = ~sclk_q[STAGES-1] & sclk_last_q;
  assign sel_o  = ~csn_q[STAGES-1];
  assign sdi_o  = sdi_q[STAGES-1];

  // R6: an edge pulse lasts exactly one clock
  assert_edge_single_R6: assert property (@(posedge clk_i) disable iff (!resync_n_i)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_phase_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              resync_n_i,
  input  logic              burst_en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sel_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              addr_phase_o
);
  localparam int             CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              sdo_q, wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic              step, take, shift_out, is_read;
  logic [DATA_W-1:0] rx_next;

  assign step      = sel_i && !burst_en_i;
  assign take      = step && rise_i;
  assign shift_out = step && fall_i && (phase_q == PH_DATA);
  assign rx_next   = {rx_q[DATA_W-2:0], sdi_i};
  assign is_read   = cmd_q[CMD_W-1];

  always_ff @(posedge clk_i) begin
    if (!resync_n_i) begin
      phase_q   <= PH_ADDR;
      cnt_q     <= '0;
      rx_q      <= '0;
      cmd_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (take) begin
        rx_q <= rx_next;
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          if (phase_q == PH_ADDR) begin
            cmd_q   <= rx_next[CMD_W-1:0];
            phase_q <= PH_DATA;
          end else begin
            phase_q <= PH_ADDR;
            if (!is_read && (cmd_q[ADDR_W-1:0] < ADDR_W'(NUM_REGS))) begin
              wr_en_q   <= 1'b1;
              wr_addr_q <= cmd_q[ADDR_W-1:0];
              wr_data_q <= rx_next;
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // Output shifter: loads on the first falling edge of the data byte
  always_ff @(posedge clk_i) begin
    if (!resync_n_i) begin
      sdo_q <= 1'b0;
      tx_q  <= '0;
    end else if (take && (cnt_q == LAST) && (phase_q == PH_DATA)) begin
      sdo_q <= 1'b0;
    end else if (shift_out) begin
      if (cnt_q == '0) begin
        sdo_q <= is_read & rd_data_i[DATA_W-1];
        tx_q  <= {rd_data_i[DATA_W-2:0], 1'b0};
      end else begin
        sdo_q <= is_read & tx_q[DATA_W-1];
        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign rd_addr_o    = cmd_q[ADDR_W-1:0];
  assign wr_en_o      = wr_en_q;
  assign wr_addr_o    = wr_addr_q;
  assign wr_data_o    = wr_data_q;
  assign sdo_o        = sdo_q;
  assign addr_phase_o = (phase_q == PH_ADDR);

  // R6 / R9: phase moves only on an accepted rising edge
  assert_phase_hold_R6: assert property (@(posedge clk_i) disable iff (!resync_n_i)
    !take |=> $stable(phase_q));
  // R3: a phase lasts exactly one full byte
  assert_byte_len_R3: assert property (@(posedge clk_i) disable iff (!resync_n_i)
    (phase_q != $past(phase_q)) |-> ($past(cnt_q) == LAST));
  // R7: resync returns to the start of a command byte
  assert_resync_start_R7: assert property (@(posedge clk_i)
    !resync_n_i |=> (phase_q == PH_ADDR && cnt_q == '0));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              resync_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0]   mem [NUM_REGS];
  logic [NUM_REGS-1:0] valid_q;
  logic [DATA_W-1:0]   rd_q;
  logic [IDX_W-1:0]    widx, ridx;
  logic                rd_hit;

  assign widx   = wr_addr_i[IDX_W-1:0];
  assign ridx   = rd_addr_i[IDX_W-1:0];
  assign rd_hit = (rd_addr_i < ADDR_W'(NUM_REGS)) && valid_q[ridx];

  // Storage array: no reset, so it maps to RAM
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[widx] <= wr_data_i;
  end

  // Per-word valid flags give the clear-on-resync behaviour
  always_ff @(posedge clk_i) begin
    if (!resync_n_i)  valid_q <= '0;
    else if (wr_en_i) valid_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!resync_n_i) rd_q <= '0;
    else             rd_q <= rd_hit ? mem[ridx] : '0;
  end

  assign rd_data_o = rd_q;

  // R8: the sequencer never forwards an out-of-range write
  assert_wr_in_range_R8: assert property (@(posedge clk_i) disable iff (!resync_n_i)
    wr_en_i |-> (wr_addr_i < ADDR_W'(NUM_REGS)));
  // R1: a fresh resync leaves the bank empty
  assert_bank_clear_R1: assert property (@(posedge clk_i)
    !resync_n_i |=> (valid_q == '0 && rd_q == '0));
endmodule

// File: rtl/spi_phase_target.sv
module spi_phase_target #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic resync_n_i,
  input  logic burst_en_i,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic addr_phase_o
);
  logic              rise, fall, sel, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .resync_n_i (resync_n_i),
    .sclk_i     (sclk_i),
    .cs_n_i     (cs_n_i),
    .sdi_i      (sdi_i),
    .rise_o     (rise),
    .fall_o     (fall),
    .sel_o      (sel),
    .sdi_o      (sdi_s)
  );

  spi_frame_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_seq (
    .clk_i        (clk_i),
    .resync_n_i   (resync_n_i),
    .burst_en_i   (burst_en_i),
    .rise_i       (rise),
    .fall_i       (fall),
    .sel_i        (sel),
    .sdi_i        (sdi_s),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .sdo_o        (sdo_o),
    .addr_phase_o (addr_phase_o)
  );

  spi_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i      (clk_i),
    .resync_n_i (resync_n_i),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  // R10: output pin is silent during the command byte
  assert_sdo_quiet_R10: assert property (@(posedge clk_i) disable iff (!resync_n_i)
    addr_phase_o |-> !sdo_o);
endmodule

// File: tb/spi_phase_target_tb.sv
module spi_phase_target_tb;
  localparam int HALF = 6;
  localparam int NVEC = 12;
  // {command, write data, expected read data}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h03, 8'hA5, 8'h00}, {8'h00, 8'h3C, 8'h00}, {8'h0F, 8'hFF, 8'h00},
    {8'h83, 8'h00, 8'hA5}, {8'h80, 8'h00, 8'h3C}, {8'h8F, 8'h00, 8'hFF},
    {8'h85, 8'h00, 8'h00}, {8'h20, 8'h77, 8'h00}, {8'hA0, 8'h00, 8'h00},
    {8'h90, 8'h00, 8'h00}, {8'h03, 8'h5A, 8'h00}, {8'h83, 8'h00, 8'h5A}
  };

  logic clk = 1'b0;
  logic resync_n = 1'b0, burst_en = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, addr_phase;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  spi_phase_target u_dut (
    .clk_i(clk), .resync_n_i(resync_n), .burst_en_i(burst_en), .sclk_i(sclk),
    .cs_n_i(cs_n), .sdi_i(sdi), .sdo_o(sdo), .addr_phase_o(addr_phase)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic so);
    @(negedge clk) sdi = b;
    repeat (HALF) @(negedge clk);
    so = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, output logic [7:0] rd);
    logic so;
    for (int i = 7; i >= 0; i--) sbit(cmd[i], so);
    for (int i = 7; i >= 0; i--) begin
      sbit(wd[i], so);
      rd[i] = so;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_resync();
    @(negedge clk) resync_n = 1'b0;
    repeat (3) @(negedge clk);
    resync_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic so;
    repeat (4) @(negedge clk);
    resync_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 phase after reset", {7'd0, addr_phase}, 8'h01);
    check("R1 sdo after reset", {7'd0, sdo}, 8'h00);
    cs_n = 1'b0;
    for (int a = 0; a < 16; a++) begin
      xfer(8'h80 | 8'(a), 8'h00, rd);
      check("R1 register cleared", rd, 8'h00);
    end

    // Table walk: R4 writes, R5 reads, R8 out of range, R10 quiet writes
    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][23:16], VEC[v][15:8], rd);
      if (VEC[v][23]) check("R5/R8 read data", rd, VEC[v][7:0]);
      else            check("R10 sdo during write", rd, 8'h00);
    end

    // R2 / R3: phase across one frame
    for (int i = 0; i < 7; i++) sbit(1'b0, so);
    check("R2 phase after 7 bits", {7'd0, addr_phase}, 8'h01);
    sbit(1'b1, so);
    check("R2 phase after 8 bits", {7'd0, addr_phase}, 8'h00);
    for (int i = 0; i < 7; i++) sbit(1'b0, so);
    check("R3 phase after 15 bits", {7'd0, addr_phase}, 8'h00);
    sbit(1'b0, so);
    repeat (HALF) @(negedge clk);
    check("R3 phase after 16 bits", {7'd0, addr_phase}, 8'h01);

    // R6: paused frame, write 0xC3 to register 7
    for (int i = 7; i >= 4; i--) sbit(logic'(8'h07 >> i), so);
    cs_n = 1'b1;
    for (int i = 0; i < 9; i++) sbit(1'b1, so);
    cs_n = 1'b0;
    check("R6 phase held while deselected", {7'd0, addr_phase}, 8'h01);
    for (int i = 3; i >= 0; i--) sbit(logic'(8'h07 >> i), so);
    for (int i = 7; i >= 5; i--) sbit(logic'(8'hC3 >> i), so);
    cs_n = 1'b1;
    for (int i = 0; i < 9; i++) sbit(1'b0, so);
    cs_n = 1'b0;
    check("R6 data phase held while deselected", {7'd0, addr_phase}, 8'h00);
    for (int i = 4; i >= 0; i--) sbit(logic'(8'hC3 >> i), so);
    repeat (HALF) @(negedge clk);
    xfer(8'h87, 8'h00, rd);
    check("R6 resumed write stored", rd, 8'hC3);

    // R9: burst_en high ignores SCLK
    burst_en = 1'b1;
    for (int i = 0; i < 8; i++) sbit(1'b1, so);
    check("R9 phase unchanged", {7'd0, addr_phase}, 8'h01);
    burst_en = 1'b0;
    repeat (3) @(negedge clk);
    xfer(8'h83, 8'h00, rd);
    check("R9 alignment kept", rd, 8'h5A);

    // R7: controller loses step, target drifts into the data byte
    for (int i = 0; i < 8; i++) sbit(1'b0, so);
    check("R7 target drifted to data", {7'd0, addr_phase}, 8'h00);
    for (int i = 0; i < 3; i++) sbit(1'b1, so);
    do_resync();
    check("R7 phase after resync", {7'd0, addr_phase}, 8'h01);
    check("R7 sdo after resync", {7'd0, sdo}, 8'h00);
    xfer(8'h83, 8'h00, rd);
    check("R1 register cleared by resync", rd, 8'h00);
    xfer(8'h0A, 8'h96, rd);
    xfer(8'h8A, 8'h00, rd);
    check("R7 fresh frame after resync", rd, 8'h96);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule